// File: doc/BRIEF.md
# PLL Frequency Lock Monitor

This block decides whether a phase-locked loop has settled on the frequency its feedback divider asks for. It watches two strobes in the system clock domain: one pulses once per reference-clock period and the other once per divided feedback-clock period. Over a measurement window of a fixed number of reference periods, it counts feedback strobes. At the end of the window it compares that count with the value the divider setting predicts. The comparison is of frequency only; phase plays no part. Because the window is a fixed number of reference periods, a faster reference gives a quicker verdict.

The result is a status bit that software can only read. Entering lock needs a close match. Leaving lock needs a larger error. This hysteresis stops the bit from chattering near the edge of the tolerance. Every change of the status bit can latch a sticky interrupt flag, but only while the interrupt enable is high. Software clears the flag with a one-cycle clear pulse. When the divider setting changes, the measurement starts over and the status bit drops at once.

Top module: `pll_lock_monitor`

## Requirements
- R1: A measurement window closes on the 16th reference strobe (parameter `WIN_LEN`) counted since the last window end, reset or restart. Feedback strobes are counted from the first cycle after that point up to and including the closing cycle.
- R2: The target count is `WIN_LEN` × (`div_sel` + 1), where `div_sel` is an unsigned 6-bit value. While unlocked, a window whose count differs from the target by at most `LOCK_TOL` (1) sets `locked` on the clock edge that closes the window.
- R3: While locked, a window whose count differs from the target by more than `LOCK_TOL` but not more than `UNLOCK_TOL` (2) leaves `locked` at 1. While unlocked, such a window leaves `locked` at 0.
- R4: While locked, a window whose count differs from the target by more than `UNLOCK_TOL` clears `locked` on the clock edge that closes the window.
- R5: When `irq_en` is 1 and `locked` changes in either direction, `irq_flag` is 1 from the following cycle.
- R6: When `irq_en` is 0, a change of `locked` does not set `irq_flag`.
- R7: `irq_flag` stays at 1 until a cycle with `irq_clr` high and no new toggle. A toggle in the same cycle as the clear wins.
- R8: A cycle in which `div_sel` differs from its value in the previous cycle forces `locked` to 0 and restarts the window count and the feedback count.
- R9: A synchronous active-high `rst` clears `locked`, `irq_flag` and all counters. The stored divider value resets to 0.
- R10: `locked` changes only on the edge that closes a window or on a divider change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference-clock period |
| fb_tick | input | 1 | One-cycle strobe per divided feedback-clock period |
| div_sel | input | 6 | Feedback divider setting; the division ratio is this value plus one |
| irq_en | input | 1 | Lets a lock-status change latch the interrupt flag |
| irq_clr | input | 1 | Pulse that clears the interrupt flag |
| locked | output | 1 | Read-only lock status |
| irq_flag | output | 1 | Sticky interrupt request |

## Verification
A table of windows is stepped through at a divider setting of 1 (target 32). The feedback counts are chosen to sit at different distances from the target: far off, one off, two off and three off. Reached in both the locked and the unlocked state, these counts separate the entry tolerance from the exit tolerance, so a design that uses a single threshold fails. Directed tests then check the following:
- A divider change made halfway through a window: the final lock depends on whether the partial counts were really discarded.
- A divider of 63 (target 1024): this exercises counter width.
- The interrupt flag with the enable both high and low, including a toggle in the same cycle as a clear.
- That the status holds steady until the window's closing strobe.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    localparam int MEAS_W = 16;

    typedef logic [MEAS_W-1:0] meas_t;

    typedef enum logic [1:0] {
        VERD_HOLD  = 2'd0,
        VERD_ENTER = 2'd1,
        VERD_LEAVE = 2'd2
    } verdict_e;

    typedef struct packed {
        logic  done;
        meas_t count;
    } window_rpt_t;

    function automatic meas_t abs_gap(meas_t a, meas_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic meas_t sat_inc(meas_t a);
        return (a == '1) ? a : a + meas_t'(1);
    endfunction

endpackage

// File: rtl/ref_window_timer.sv
module ref_window_timer #(
    parameter int WIN_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic ref_tick,
    output logic win_done
);
    localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

    logic [WW-1:0] ref_cnt;

    assign win_done = ref_tick && !restart && (ref_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            ref_cnt <= '0;
        else if (ref_tick)
            ref_cnt <= (ref_cnt == LAST) ? '0 : ref_cnt + WW'(1);
    end

    // R1: a closed window starts the next one from zero
    assert_window_wraps_R1: assert property (@(posedge clk) disable iff (rst)
        win_done |=> (ref_cnt == '0));

    // R8: a restart discards the partial window
    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ref_cnt == '0));

endmodule

// File: rtl/fb_edge_counter.sv
module fb_edge_counter
    import lockmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        fb_tick,
    input  logic        win_done,
    output window_rpt_t rpt
);
    meas_t fb_cnt;

    always_comb begin
        rpt.done  = win_done;
        rpt.count = fb_tick ? sat_inc(fb_cnt) : fb_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || restart || win_done)
            fb_cnt <= '0;
        else if (fb_tick)
            fb_cnt <= sat_inc(fb_cnt);
    end

    // R1: counting starts from zero after each window
    assert_fb_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (win_done || restart) |=> (fb_cnt == '0));

endmodule

// File: rtl/lock_judge.sv
module lock_judge
    import lockmon_pkg::*;
#(
    parameter int LOCK_TOL   = 1,
    parameter int UNLOCK_TOL = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  window_rpt_t rpt,
    input  meas_t       target,
    input  logic        irq_en,
    input  logic        irq_clr,
    output logic        locked,
    output logic        irq_flag
);
    localparam meas_t ENTER_LIM = meas_t'(LOCK_TOL);
    localparam meas_t LEAVE_LIM = meas_t'(UNLOCK_TOL);

    meas_t    gap;
    verdict_e verdict;
    logic     lock_nxt;
    logic     toggle;

    always_comb begin
        gap     = abs_gap(rpt.count, target);
        verdict = VERD_HOLD;
        if (rpt.done) begin
            if (!locked && gap <= ENTER_LIM)
                verdict = VERD_ENTER;
            else if (locked && gap > LEAVE_LIM)
                verdict = VERD_LEAVE;
        end
        if (restart)
            lock_nxt = 1'b0;
        else if (verdict == VERD_ENTER)
            lock_nxt = 1'b1;
        else if (verdict == VERD_LEAVE)
            lock_nxt = 1'b0;
        else
            lock_nxt = locked;
        toggle = (lock_nxt != locked);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            locked <= lock_nxt;
            if (irq_en && toggle)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;
        end
    end

    // R10: status moves only at a window end or a restart
    assert_hold_midwindow_R10: assert property (@(posedge clk) disable iff (rst)
        (!rpt.done && !restart) |=> $stable(locked));

    // R8: a restart leaves the monitor unlocked
    assert_restart_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> !locked);

    // R4: a large error at a window end drops lock
    assert_leave_R4: assert property (@(posedge clk) disable iff (rst)
        (locked && rpt.done && gap > LEAVE_LIM) |=> !locked);

    // R2: a close match at a window end enters lock
    assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
        (!locked && rpt.done && !restart && gap <= ENTER_LIM) |=> locked);

    // R5: an enabled toggle latches the flag
    assert_irq_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_en && toggle) |=> irq_flag);

    // R7: the flag is sticky until cleared
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R9: reset clears status and flag
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!locked && !irq_flag));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import lockmon_pkg::*;
#(
    parameter int WIN_LEN    = 16,
    parameter int DIV_W      = 6,
    parameter int LOCK_TOL   = 1,
    parameter int UNLOCK_TOL = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             fb_tick,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             locked,
    output logic             irq_flag
);
    logic [DIV_W-1:0] div_q;
    logic             div_chg;
    logic             win_done;
    window_rpt_t      rpt;
    meas_t            target;

    assign div_chg = (div_sel != div_q);
    assign target  = meas_t'(WIN_LEN) * (meas_t'(div_q) + meas_t'(1));

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else
            div_q <= div_sel;
    end

    ref_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (div_chg),
        .ref_tick (ref_tick),
        .win_done (win_done)
    );

    fb_edge_counter u_fbcnt (
        .clk      (clk),
        .rst      (rst),
        .restart  (div_chg),
        .fb_tick  (fb_tick),
        .win_done (win_done),
        .rpt      (rpt)
    );

    lock_judge #(.LOCK_TOL(LOCK_TOL), .UNLOCK_TOL(UNLOCK_TOL)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .restart  (div_chg),
        .rpt      (rpt),
        .target   (target),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .locked   (locked),
        .irq_flag (irq_flag)
    );

    // R8: a divider change is seen as unlocked on the next cycle
    assert_divchg_unlock_R8: assert property (@(posedge clk) disable iff (rst)
        div_chg |=> !locked);

    // R6: with the enable low the flag cannot rise
    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !irq_flag) |=> !irq_flag);

endmodule

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       fb_tick = 1'b0;
    logic [5:0] div_sel = 6'd0;
    logic       irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       locked;
    logic       irq_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pll_lock_monitor dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .div_sel(div_sel), .irq_en(irq_en), .irq_clr(irq_clr),
        .locked(locked), .irq_flag(irq_flag)
    );

    // divider fixed at 1, target 32
    localparam int NV = 8;
    localparam int VEC_N  [NV] = '{20, 33, 34, 30, 35, 34, 32, 31};
    localparam bit VEC_LK [NV] = '{0,  1,  1,  1,  0,  0,  1,  1};

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(logic r, logic f);
        ref_tick = r;
        fb_tick  = f;
        @(negedge clk);
        ref_tick = 1'b0;
        fb_tick  = 1'b0;
    endtask

    task automatic feed(int n_fb, int n_ref);
        for (int i = 0; i < n_fb; i++) tick(1'b0, 1'b1);
        for (int i = 0; i < n_ref; i++) tick(1'b1, 1'b0);
    endtask

    task automatic set_div(logic [5:0] d);
        div_sel = d;
        tick(1'b0, 1'b0);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset locked", locked, 1'b0);
        chk("R9 reset irq_flag", irq_flag, 1'b0);
        rst = 1'b0;

        set_div(6'd1);
        for (int v = 0; v < NV; v++) begin
            feed(VEC_N[v], 16);
            chk($sformatf("R2/R3/R4 vector %0d", v), locked, VEC_LK[v]);
        end
        chk("R6 no irq while disabled", irq_flag, 1'b0);

        // R10: hold through the window until the 16th strobe
        feed(40, 15);
        chk("R10 held before window end", locked, 1'b1);
        irq_en = 1'b1;
        tick(1'b1, 1'b0);
        chk("R4 unlock at 16th strobe", locked, 1'b0);
        @(negedge clk);
        chk("R5 irq on unlock", irq_flag, 1'b1);
        clear_irq();
        chk("R7 clear drops flag", irq_flag, 1'b0);

        feed(32, 16);
        chk("R2 relock", locked, 1'b1);
        chk("R5 irq on lock", irq_flag, 1'b1);
        feed(32, 16);
        chk("R7 sticky without clear", irq_flag, 1'b1);

        // R7: toggle in the same cycle as a clear keeps the flag
        clear_irq();
        feed(40, 15);
        irq_clr = 1'b1;
        tick(1'b1, 1'b0);
        irq_clr = 1'b0;
        chk("R7 toggle beats clear", irq_flag, 1'b1);
        clear_irq();

        irq_en = 1'b0;
        feed(32, 16);
        chk("R2 lock with irq disabled", locked, 1'b1);
        chk("R6 flag stays low", irq_flag, 1'b0);

        // R8: divider change forces unlock
        set_div(6'd2);
        chk("R8 divider change unlocks", locked, 1'b0);
        feed(48, 16);
        chk("R2 lock at div 2", locked, 1'b1);

        // R8: partial window discarded
        feed(10, 8);
        set_div(6'd0);
        chk("R8 unlock on change midwindow", locked, 1'b0);
        feed(16, 16);
        chk("R8 restart discards partial counts", locked, 1'b1);

        // R1: window length exact; 15 strobes leave status alone
        set_div(6'd3);
        feed(64, 15);
        chk("R1 no verdict after 15 strobes", locked, 1'b0);
        tick(1'b1, 1'b0);
        chk("R1 verdict on 16th strobe", locked, 1'b1);

        // R2 large divider: target 1024
        set_div(6'd63);
        feed(1023, 16);
        chk("R2 lock at div 63", locked, 1'b1);
        feed(1026, 16);
        chk("R3 hold at div 63 gap 2", locked, 1'b1);

        // R9: reset mid-operation
        irq_en = 1'b1;
        feed(1000, 16);
        chk("R5 flag before reset", irq_flag, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears locked", locked, 1'b0);
        chk("R9 reset clears flag", irq_flag, 1'b0);
        rst = 1'b0;

        finish_run();
    end

endmodule